// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block holds the pending-event flags and the per-source enable mask of a small peripheral, and combines them into one interrupt line. Three neighbouring blocks report events with one-cycle set pulses: a shift unit and two timers. Each event lands in a fixed bit of an 8-bit flag register. A flag is cleared in two ways. The host can write a 1 to its bit, or a neighbour can send a one-cycle strobe when its own data is read, because that read acknowledges the event.

The host sees two byte-wide registers, chosen by a one-bit select. Select 0 is the flag register and select 1 is the enable register. The enable register takes its writes in set-or-clear form, with bit 7 choosing the direction. This lets software change single enables without a read-modify-write. On reads, bit 7 of each register carries extra meaning. Only the shift and timer 1 sources drive the interrupt output. The timer 2 flag is only visible by polling.

There is no data stream through this block. Every pin is a plain control or status signal, and there is no valid/ready handshake.

Top module: `ifc_ctrl`

## Requirements
- R1: A one-cycle pulse on `set_src[0]` (shift), `set_src[1]` (timer 2) or `set_src[2]` (timer 1) sets flag bit 2, 5 or 6 respectively on the next clock edge. All other flag bits always read 0.
- R2: A write with `wr_sel`=0 clears every flag bit whose `wr_data` bit is 1 and leaves flag bits written as 0 unchanged.
- R3: A write with `wr_sel`=1 and `wr_data[7]`=1 sets each enable bit 6:0 whose `wr_data` bit is 1 and leaves the others unchanged.
- R4: A write with `wr_sel`=1 and `wr_data[7]`=0 clears each enable bit 6:0 whose `wr_data` bit is 1 and leaves the others unchanged.
- R5: With `rd_sel`=1, `rd_data` is {1, enable[6:0]}: bit 7 always reads 1.
- R6: With `rd_sel`=0, `rd_data[6:0]` shows the flags, and `rd_data[7]` is 1 exactly when some flag bit and its enable bit are both 1. This includes timer 2.
- R7: `irq` depends only on flag bits 2 and 6 and their enables. A pending, enabled timer 2 flag (bit 5) does not raise `irq`.
- R8: After reset, all flags and all enables are 0 and `irq` is 0. Reads then return 0x00 (flags) and 0x80 (enables).
- R9: When a set pulse and a clear (host write or read strobe) hit the same flag in the same cycle, the flag ends up set.
- R10: `irq` is registered. In each cycle it equals the OR of (flag AND enable) over bits 2 and 6, taken from the previous cycle's register state.
- R11: A one-cycle pulse on `rdclr_src[0]`, `rdclr_src[1]` or `rdclr_src[2]` clears flag bit 2, 5 or 6 respectively on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_src | input | 3 | Event set pulses: [0] shift, [1] timer 2, [2] timer 1 |
| rdclr_src | input | 3 | Read-side-effect clear strobes, same source order |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Write target: 0 flag register, 1 enable register |
| wr_data | input | 8 | Host write data |
| rd_sel | input | 1 | Read source: 0 flag register, 1 enable register |
| rd_data | output | 8 | Read data (combinational from register state) |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench targets four hazards.

- **Set and clear in the same cycle.** A set pulse can coincide with a host clear or a read strobe. A design where clear has priority would read the flag back as 0 and lose the event.
- **Timer 2 as a source.** A timer 2 flag is raised and enabled on its own. A design that ORs every source into the interrupt would raise `irq`, while the summary bit 7 of the flag read must still report the pending source.
- **Direction bit of enable writes.** Writes alternate between set form and clear form. A design that decodes bit 7 the wrong way round, or stores that bit, would show wrong enables or a wrong bit 7 on read.
- **Timing of `irq`.** `irq` is compared every cycle against the state one edge earlier. A design that drives it combinationally, or adds an extra stage, would mismatch on the cycle after each change.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int DW    = 8;
  localparam int N_SRC = 3;

  // bit position of each event source in the flag byte
  function automatic int src_pos(input int idx);
    case (idx)
      0:       return 2;
      1:       return 5;
      default: return 6;
    endcase
  endfunction

  // turn a per-source selection into a byte-position mask
  function automatic logic [DW-1:0] src_mask(input logic [N_SRC-1:0] sel);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < N_SRC; i++)
      if (sel[i]) m[src_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ifc_flag_bank.sv
module ifc_flag_bank
  import ifc_pkg::*;
#(
  parameter int W    = DW,
  parameter int NSRC = N_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_src,
  input  logic [NSRC-1:0] rdclr_src,
  input  logic            host_clr,
  input  logic [W-1:0]    host_data,
  output logic [W-1:0]    flag_vec
);
  logic [NSRC-1:0] fq;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int POS = src_pos(g);
    logic drop;
    assign drop = rdclr_src[g] | (host_clr & host_data[POS]);
    always_ff @(posedge clk) begin
      if (!rst_n)          fq[g] <= 1'b0;
      else if (set_src[g]) fq[g] <= 1'b1;   // set has priority over any clear
      else if (drop)       fq[g] <= 1'b0;
    end
  end

  always_comb begin
    flag_vec = '0;
    for (int i = 0; i < NSRC; i++)
      flag_vec[src_pos(i)] = fq[i];
  end
endmodule

// File: rtl/ifc_enable_reg.sv
module ifc_enable_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] data,
  output logic [W-2:0] en_vec
);
  localparam int DIR = W - 1;

  always_ff @(posedge clk) begin
    if (!rst_n)       en_vec <= '0;
    else if (wr) begin
      if (data[DIR])  en_vec <= en_vec | data[DIR-1:0];
      else            en_vec <= en_vec & ~data[DIR-1:0];
    end
  end
endmodule

// File: rtl/ifc_irq_out.sv
module ifc_irq_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flag_vec,
  input  logic [W-2:0] en_vec,
  input  logic [W-1:0] irq_mask,
  output logic         pend_any,
  output logic         irq
);
  logic [W-1:0] live;

  assign live     = flag_vec & {1'b0, en_vec};
  assign pend_any = |live;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(live & irq_mask);
  end
endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl
  import ifc_pkg::*;
#(
  parameter logic [N_SRC-1:0] IRQ_SRC = 3'b101  // shift and timer 1 drive irq
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_src,
  input  logic [N_SRC-1:0] rdclr_src,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_sel,
  output logic [DW-1:0]    rd_data,
  output logic             irq
);
  localparam logic [DW-1:0] IRQ_MASK = src_mask(IRQ_SRC);

  logic [DW-1:0] flag_vec;
  logic [DW-2:0] en_vec;
  logic          pend_any;

  ifc_flag_bank #(.W(DW), .NSRC(N_SRC)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_src   (set_src),
    .rdclr_src (rdclr_src),
    .host_clr  (wr_en & ~wr_sel),
    .host_data (wr_data),
    .flag_vec  (flag_vec)
  );

  ifc_enable_reg #(.W(DW)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_en & wr_sel),
    .data   (wr_data),
    .en_vec (en_vec)
  );

  ifc_irq_out #(.W(DW)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_vec (flag_vec),
    .en_vec   (en_vec),
    .irq_mask (IRQ_MASK),
    .pend_any (pend_any),
    .irq      (irq)
  );

  assign rd_data = rd_sel ? {1'b1, en_vec} : {pend_any, flag_vec[DW-2:0]};
endmodule

// File: rtl/ifc_ctrl_chk.sv
module ifc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] set_src,
  input logic [2:0] rdclr_src,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic       rd_sel,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic [7:0] flag_vec,
  input logic [6:0] en_vec
);
  logic [7:0] set_bits;
  assign set_bits = {1'b0, set_src[2], set_src[1], 2'b00, set_src[0], 2'b00};

  // R10 and R7: irq follows bits 2 and 6 of the previous state only
  assert_irq_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(flag_vec & {1'b0, en_vec} & 8'h44))));

  // R9: a set pulse always lands, whatever clear arrives with it
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_src) |=> ((flag_vec & $past(set_bits)) == $past(set_bits)));

  // R5: enable readback carries bit 7 high
  assert_en_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> rd_data[7]);

  // R2: host clear of timer 1 flag when no set collides
  assert_wr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[6] && !set_src[2]) |=> !flag_vec[6]);

  // R3: set-form enable write raises every selected bit
  assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && wr_data[7]) |=>
      ((en_vec & $past(wr_data[6:0])) == $past(wr_data[6:0])));

  // R4: clear-form enable write drops every selected bit
  assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !wr_data[7]) |=> ((en_vec & $past(wr_data[6:0])) == 7'd0));
endmodule

bind ifc_ctrl ifc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .set_src(set_src), .rdclr_src(rdclr_src),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
  .rd_data(rd_data), .irq(irq), .flag_vec(flag_vec), .en_vec(en_vec)
);

// File: tb/sim_ifc_ctrl.sv
module sim_ifc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] set_src, rdclr_src;
  logic       wr_en, wr_sel, rd_sel;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model
  logic [7:0] mf;
  logic [6:0] me;
  logic       mirq;

  always #5 clk = ~clk;

  ifc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .set_src(set_src), .rdclr_src(rdclr_src),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [7:0] pos_bits(input logic [2:0] s);
    return {1'b0, s[2], s[1], 2'b00, s[0], 2'b00};
  endfunction

  function automatic logic [7:0] exp_rd(input logic sel);
    if (sel) return {1'b1, me};
    return {|(mf & {1'b0, me}), mf[6:0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    set_src = '0; rdclr_src = '0; wr_en = 0; wr_sel = 0; wr_data = '0; rd_sel = 0;
  endtask

  // one clock with the current inputs: check read, step model, check irq
  task automatic cyc(input string req);
    logic [7:0] nf;
    #1;
    chk({req, " rd"}, rd_data, exp_rd(rd_sel));
    @(posedge clk);
    mirq = |(mf & {1'b0, me} & 8'h44);
    nf = mf & ~pos_bits(rdclr_src);
    if (wr_en && !wr_sel) nf = nf & ~wr_data;
    nf = (nf | pos_bits(set_src)) & 8'h64;
    if (wr_en && wr_sel)
      me = wr_data[7] ? (me | wr_data[6:0]) : (me & ~wr_data[6:0]);
    mf = nf;
    @(negedge clk);
    chk({req, " irq"}, {7'd0, irq}, {7'd0, mirq});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst_n = 0;
    mf = '0; me = '0; mirq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R8 reset state, R5 enable msb
    cyc("R8 flags");
    rd_sel = 1; cyc("R8 R5 enables");

    // R3: set-form enable write
    idle(); wr_en = 1; wr_sel = 1; wr_data = 8'hA0; cyc("R3");
    idle(); rd_sel = 1; cyc("R3 readback");

    // R1, R7: timer 2 pending and enabled, no irq; R6 summary
    idle(); set_src = 3'b010; cyc("R1 t2 set");
    idle(); cyc("R7 R6 t2 no irq");
    idle(); cyc("R7 R6 t2 hold");

    // R1, R10: timer 1 and shift set, enable them
    idle(); wr_en = 1; wr_sel = 1; wr_data = 8'hC4; cyc("R3 en t1 shift");
    idle(); set_src = 3'b100; cyc("R1 t1 set");
    idle(); cyc("R10 irq rise");
    idle(); cyc("R10 irq hold");

    // R9: host clear and set collide
    idle(); wr_en = 1; wr_data = 8'hFF; set_src = 3'b100; cyc("R9 wr vs set");
    idle(); cyc("R9 after");

    // R11: read strobe clears, then collides with set
    idle(); rdclr_src = 3'b100; cyc("R11 rdclr t1");
    idle(); cyc("R11 after");
    idle(); set_src = 3'b001; cyc("R1 shift set");
    idle(); rdclr_src = 3'b001; set_src = 3'b001; cyc("R9 rdclr vs set");
    idle(); cyc("R9 R10 after");

    // R2: partial clear leaves others
    idle(); set_src = 3'b111; cyc("R1 all set");
    idle(); wr_en = 1; wr_data = 8'h20; cyc("R2 clear t2");
    idle(); cyc("R2 after");

    // R4: clear-form enable write
    idle(); wr_en = 1; wr_sel = 1; wr_data = 8'h44; cyc("R4");
    idle(); rd_sel = 1; cyc("R4 readback");
    idle(); cyc("R4 R10 irq fall");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      idle();
      set_src   = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd0;
      rdclr_src = ($urandom_range(0, 4) == 0) ? 3'($urandom) : 3'd0;
      wr_en     = ($urandom_range(0, 3) == 0);
      wr_sel    = 1'($urandom);
      wr_data   = 8'($urandom);
      rd_sel    = 1'($urandom);
      cyc("R1 R2 R3 R4 R6 R7 R9 R10 R11 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule